// File: doc/BRIEF.md
# Newton-Raphson Reciprocal Divider

This block divides one normalized fixed-point significand by another. Both operands lie in [1,2) and use an unsigned Q1.31 encoding: bit 31 has weight 1 and bit 0 has weight 2^-31. The block does not produce quotient digits one at a time. It first estimates 1/divisor from a small seed table. It then sharpens that estimate with Newton-Raphson steps, x' = x·(2 − b·x). Each step about doubles the number of correct bits. A last multiplication by the dividend gives the quotient.

All products come from one shared 34-bit multiplier. A small controller issues the multiplier steps in order: one b·x product and one x·(2 − b·x) product per refinement, then the final a·x product. The value 2 − b·x is taken as the 34-bit two's complement of the product held in Q1.33 format. The block accepts a one-cycle start request when idle and raises `done` for one cycle when the result is ready. It keeps both the quotient and the refined reciprocal on its outputs until the next accepted request. The seed table is computed while the design is built, from the 8 divisor fraction bits that follow the leading one.

Top module: `nr_recip_div`

## Requirements
- R1: After synchronous active-low reset, `busy` and `done` are 0, and `quotient` and `recip` are 0. This holds even when reset is applied in the middle of an operation.
- R2: A `start` sampled high while `busy` is low is accepted. `busy` is high from the next cycle through the cycle in which `done` is high.
- R3: A `start` sampled while `busy` is high is ignored. The running operation finishes with the operands captured when it was accepted, even if the operand inputs change.
- R4: The reciprocal is formed from a seed indexed by divisor bits [30:23]. The seed is the reciprocal of the centre of that interval, kept to 16 fraction bits. Every b·x product used in a refinement lies within 2^-7 of 1.0. `recip` is unsigned Q1.33 (bit 33 has weight 1) and lies within 2 units of floor(2^64 / divisor).
- R5: `quotient` is unsigned Q1.31 and lies within 1 unit of floor(dividend · 2^31 / divisor).
- R6: With ITERS refinements (default 2), `done` is high in the cycle after the (2·ITERS+1)-th rising edge that follows the accepting edge. It is low in every cycle before that.
- R7: `done` is high for exactly one cycle. In the following cycle both `done` and `busy` are low.
- R8: Between `done` and the next accepted `start`, `quotient` and `recip` do not change, whatever the operand inputs do.
- R9: At the boundaries, the R4 and R5 tolerances still hold. These cases are divisor 1.0 (recip near 2^33, quotient near the dividend), dividend equal to divisor (quotient near 2^31), and operands at the all-ones maximum.
- R10: A `start` raised in the first idle cycle after `done` is accepted, so operations can run back to back with one idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a division; accepted only while idle |
| dividend | input | 32 | Dividend a, Q1.31, bit 31 set |
| divisor | input | 32 | Divisor b, Q1.31, bit 31 set |
| busy | output | 1 | An operation is in progress (including its done cycle) |
| done | output | 1 | One-cycle pulse: results are valid |
| quotient | output | 32 | a/b in Q1.31, held until the next accepted start |
| recip | output | 34 | 1/b in Q1.33, held until the next accepted start |

## Verification
Assertions placed in the RTL check several properties on every cycle. They check that `done` is a single-cycle pulse followed by idle, and that an idle start raises `busy`. They check that the captured operands stay frozen while busy, and that the results hold between completion and the next request. They also check the exact cycle count from acceptance to `done`, and that each refinement's b·x product stays within 2^-7 of one, which is the internal sign that the seed is converging.

Some behaviour only the bench scenarios can show, by comparing the results with independently computed exact divisions. These are the numerical accuracy of the reciprocal and the quotient, the boundary operands, the effect of reset in the middle of an operation, and the fact that the stall case really returns the first operands' result.

// File: rtl/nr_div_pkg.sv
// Package nr_div_pkg
// Types shared by the Newton-Raphson divider and the constant function
// that computes its seed table while the design is built.
// Assumes: the seed index covers the fraction bits after the leading one,
// and (SEED_FRAC + IDX_BITS + 1) < 32 so the numerator fits in 32 bits.
package nr_div_pkg;

    // Operand pairing applied to the single shared multiplier.
    typedef enum logic [1:0] {
        MSEL_BX = 2'd0,   // divisor * reciprocal estimate
        MSEL_XC = 2'd1,   // reciprocal estimate * (2 - product)
        MSEL_AX = 2'd2    // dividend * refined reciprocal
    } mul_sel_e;

    // Sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_PROD = 3'd1,
        ST_CORR = 3'd2,
        ST_QUOT = 3'd3,
        ST_DONE = 3'd4
    } nr_state_e;

    // Reciprocal of the centre of seed interval idx, with frac_bits fraction bits.
    // Interval centre = (2^(idx_bits+1) + 2*idx + 1) / 2^(idx_bits+1).
    function automatic int unsigned seed_value(input int unsigned idx,
                                               input int unsigned idx_bits,
                                               input int unsigned frac_bits);
        int unsigned num;
        int unsigned den;
        num = 32'd1 << (frac_bits + idx_bits + 32'd1);
        den = (32'd1 << (idx_bits + 32'd1)) + (32'd2 * idx) + 32'd1;
        return num / den;
    endfunction

endpackage

// File: rtl/nr_seed_rom.sv
// Module nr_seed_rom
// Read-only table of initial reciprocal estimates. Every entry is computed
// while the design is built by nr_div_pkg::seed_value, so the table needs no
// data file. Entry i approximates 1/(1 + (i + 0.5)/2^IDX_BITS) and has
// SEED_FRAC fraction bits.
// Assumes: idx is the IDX_BITS fraction bits just below the divisor's
// leading one. All entries lie in (0.5, 1), so the top bit is always set.
module nr_seed_rom
    import nr_div_pkg::*;
#(
    parameter int IDX_BITS  = 8,
    parameter int SEED_FRAC = 16
) (
    input  logic [IDX_BITS-1:0]  idx,
    output logic [SEED_FRAC-1:0] seed
);

    localparam int ENTRIES = 1 << IDX_BITS;

    logic [SEED_FRAC-1:0] seed_tbl [ENTRIES];

    // Fill one constant entry per index.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        localparam int unsigned VAL =
            seed_value(int'(g), IDX_BITS, SEED_FRAC);
        assign seed_tbl[g] = SEED_FRAC'(VAL);
    end

    // Look up the entry for the current divisor.
    assign seed = seed_tbl[idx];

    // Every seed lies in (0.5, 1), so its leading fraction bit is set.
    always_comb begin
        AST_SEED_NORMALIZED: assert (seed[SEED_FRAC-1] == 1'b1); // R4
    end

endmodule

// File: rtl/nr_mul_unit.sv
// Module nr_mul_unit
// The one multiplier the divider shares between all its steps. It selects
// the operand pair for the current step, forms the full 2W-bit product and
// truncates it back to Q1.(W-1). The correction term 2 - p is the W-bit
// two's complement of p, because in Q1.(W-1) the value 2 equals 2^W.
// Assumes: every operand pair has a product below 2.0. Operands are
// normalized and the estimate is close to 1/b.
module nr_mul_unit
    import nr_div_pkg::*;
#(
    parameter int OPW = 32,
    parameter int W   = OPW + 2
) (
    input  mul_sel_e         sel,
    input  logic [OPW-1:0]   op_a,
    input  logic [OPW-1:0]   op_b,
    input  logic [W-1:0]     x,
    input  logic [W-1:0]     p,
    output logic [W-1:0]     res
);

    localparam int FRAC = W - 1;
    localparam int PAD  = W - OPW;
    localparam int PW   = 2 * W;

    logic [W-1:0]  corr;
    logic [W-1:0]  mul_l;
    logic [W-1:0]  mul_r;
    logic [PW-1:0] prod;
    logic          unused_prod_bits;

    // Form 2 - p as the W-bit two's complement of p.
    always_comb begin
        corr = (~p) + W'(1);
    end

    // Route the operand pair for the requested step to the multiplier.
    always_comb begin
        unique case (sel)
            MSEL_BX: begin
                mul_l = {op_b, {PAD{1'b0}}};
                mul_r = x;
            end
            MSEL_XC: begin
                mul_l = x;
                mul_r = corr;
            end
            MSEL_AX: begin
                mul_l = {op_a, {PAD{1'b0}}};
                mul_r = x;
            end
            default: begin
                mul_l = '0;
                mul_r = '0;
            end
        endcase
    end

    // Full-width product, truncated back to Q1.(W-1).
    always_comb begin
        prod = {{W{1'b0}}, mul_l} * {{W{1'b0}}, mul_r};
        res  = prod[FRAC+W-1:FRAC];
    end

    // Discarded low fraction bits and the always-zero top bit.
    assign unused_prod_bits = ^{prod[PW-1], prod[FRAC-1:0]};

endmodule

// File: rtl/nr_ctrl.sv
// Module nr_ctrl
// Controller for the divider. From idle it accepts one start request.
// It then issues ITERS refinement rounds, each made of a product step and
// a correction step, followed by one quotient step and one done cycle.
// It decodes the register write enables and the multiplier operand choice
// for the datapath.
// Assumes: ITERS >= 1. start is ignored in every state except idle.
module nr_ctrl
    import nr_div_pkg::*;
#(
    parameter int ITERS = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start,
    output logic     capture,
    output mul_sel_e sel,
    output logic     wr_p,
    output logic     wr_x,
    output logic     wr_q,
    output logic     busy,
    output logic     done
);

    localparam int ITW = (ITERS > 1) ? $clog2(ITERS) : 1;
    localparam logic [ITW-1:0] LAST_ITER = ITW'(ITERS - 1);

    nr_state_e      state_q;
    nr_state_e      state_d;
    logic [ITW-1:0] iter_q;
    logic [ITW-1:0] iter_d;

    // State and iteration registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            iter_q  <= '0;
        end else begin
            state_q <= state_d;
            iter_q  <= iter_d;
        end
    end

    // Next-state logic: product, then correction, repeated; then quotient.
    always_comb begin
        state_d = state_q;
        iter_d  = iter_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_PROD;
                    iter_d  = '0;
                end
            end
            ST_PROD: state_d = ST_CORR;
            ST_CORR: begin
                if (iter_q == LAST_ITER) begin
                    state_d = ST_QUOT;
                end else begin
                    state_d = ST_PROD;
                    iter_d  = iter_q + ITW'(1);
                end
            end
            ST_QUOT: state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Decode datapath strobes and multiplier routing from the state.
    always_comb begin
        capture = (state_q == ST_IDLE) && start;
        wr_p    = (state_q == ST_PROD);
        wr_x    = (state_q == ST_CORR);
        wr_q    = (state_q == ST_QUOT);
        busy    = (state_q != ST_IDLE);
        done    = (state_q == ST_DONE);
        unique case (state_q)
            ST_CORR: sel = MSEL_XC;
            ST_QUOT: sel = MSEL_AX;
            default: sel = MSEL_BX;
        endcase
    end

    // A request made while idle is taken up on the next cycle.
    AST_IDLE_START_ACCEPTED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy); // R2

    // Completion lasts one cycle and is followed by idle.
    AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy)); // R7

endmodule

// File: rtl/nr_recip_div.sv
// Module nr_recip_div (top)
// Multiplicative divider for normalized significands in [1,2). It loads a
// table seed for 1/b and refines it ITERS times with x' = x*(2 - b*x) on one
// shared multiplier. It then forms a*x as the quotient. Results stay
// registered until the next accepted start.
// Assumes: bit OPW-1 of both operands is set. The quotient may be one unit
// in the last place below or above the truncated exact value.
module nr_recip_div
    import nr_div_pkg::*;
#(
    parameter int OPW       = 32,
    parameter int IDX_BITS  = 8,
    parameter int SEED_FRAC = 16,
    parameter int ITERS     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [OPW-1:0]   dividend,
    input  logic [OPW-1:0]   divisor,
    output logic             busy,
    output logic             done,
    output logic [OPW-1:0]   quotient,
    output logic [OPW+1:0]   recip
);

    localparam int W    = OPW + 2;
    localparam int FRAC = W - 1;
    localparam int LAT  = 2 * ITERS + 1;
    localparam int LCW  = $clog2(LAT + 1);
    localparam logic [W-1:0] ONE_Q = W'(1) << FRAC;
    localparam logic [W-1:0] TOL_Q = W'(1) << (FRAC - 7);

    logic             capture;
    mul_sel_e         sel;
    logic             wr_p;
    logic             wr_x;
    logic             wr_q;
    logic [OPW-1:0]   a_q;
    logic [OPW-1:0]   b_q;
    logic [W-1:0]     x_q;
    logic [W-1:0]     p_q;
    logic [OPW-1:0]   q_q;
    logic [W-1:0]     res;
    logic [SEED_FRAC-1:0] seed;
    logic [W-1:0]     seed_x;
    logic [LCW-1:0]   lat_cnt;

    nr_ctrl #(
        .ITERS (ITERS)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .capture (capture),
        .sel     (sel),
        .wr_p    (wr_p),
        .wr_x    (wr_x),
        .wr_q    (wr_q),
        .busy    (busy),
        .done    (done)
    );

    nr_seed_rom #(
        .IDX_BITS  (IDX_BITS),
        .SEED_FRAC (SEED_FRAC)
    ) u_seed (
        .idx  (divisor[OPW-2 -: IDX_BITS]),
        .seed (seed)
    );

    nr_mul_unit #(
        .OPW (OPW),
        .W   (W)
    ) u_mul (
        .sel  (sel),
        .op_a (a_q),
        .op_b (b_q),
        .x    (x_q),
        .p    (p_q),
        .res  (res)
    );

    // Place the seed into Q1.(W-1): no integer bit, then the seed's fraction bits.
    assign seed_x = {1'b0, seed, {(FRAC - SEED_FRAC){1'b0}}};

    // Datapath registers: operands, estimate, product and quotient.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
            x_q <= '0;
            p_q <= '0;
            q_q <= '0;
        end else begin
            if (capture) begin
                a_q <= dividend;
                b_q <= divisor;
                x_q <= seed_x;
            end
            if (wr_p) p_q <= res;
            if (wr_x) x_q <= res;
            if (wr_q) q_q <= res[W-1:W-OPW];
        end
    end

    assign quotient = q_q;
    assign recip    = x_q;

    // Cycles elapsed since the accepting edge, for the latency check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_cnt <= '0;
        end else if (capture) begin
            lat_cnt <= '0;
        end else if (busy && (lat_cnt != LCW'(LAT))) begin
            lat_cnt <= lat_cnt + LCW'(1);
        end
    end

    // Operands captured at acceptance stay frozen for the whole operation.
    AST_OPERANDS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(a_q) && $stable(b_q))); // R3

    // Each correction step uses a product close to one.
    AST_PROD_NEAR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_x |-> ((p_q >= ONE_Q - TOL_Q) && (p_q <= ONE_Q + TOL_Q))); // R4

    // Completion arrives a fixed number of cycles after acceptance.
    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat_cnt == LCW'(LAT))); // R6

    // Results hold from completion until another request is accepted.
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done || (!busy && !start)) |=> ($stable(quotient) && $stable(recip))); // R8

endmodule

// File: tb/nr_recip_div_tb.sv
// Scoreboard bench for nr_recip_div. A driver task computes the exact
// expectations, queues them and drives each request. A monitor pops one
// item per done pulse and compares against the tolerances in the brief.
module nr_recip_div_tb;

    localparam int LAT = 5;  // 2*ITERS+1 with the default ITERS = 2

    typedef struct {
        logic [31:0]     a;
        logic [31:0]     b;
        longint unsigned q_exp;
        longint unsigned r_exp;
        string           tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [31:0] dividend;
    logic [31:0] divisor;
    logic        busy;
    logic        done;
    logic [31:0] quotient;
    logic [33:0] recip;

    int   checks   = 0;
    int   failures = 0;
    bit   finished = 1'b0;
    exp_t sb_q[$];
    exp_t mon_item;
    longint dq;
    longint dr;
    logic [31:0] last_q;
    logic [33:0] last_r;

    nr_recip_div u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .dividend (dividend),
        .divisor  (divisor),
        .busy     (busy),
        .done     (done),
        .quotient (quotient),
        .recip    (recip)
    );

    // 250 MHz clock.
    always #2 clk = ~clk;

    // Count one check; print a FAIL line with actual and expected on mismatch.
    task automatic check(input bit ok, input string req, input string what,
                         input longint unsigned act, input longint unsigned exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: compare each completed result with the next queued expectation.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R7", "done with empty scoreboard", 1, 0);
            end else begin
                mon_item = sb_q.pop_front();
                dq = longint'({32'b0, quotient}) - longint'(mon_item.q_exp);
                dr = longint'({30'b0, recip}) - longint'(mon_item.r_exp);
                check((dq >= -1) && (dq <= 1), mon_item.tag, "quotient within 1 unit",
                      {32'b0, quotient}, mon_item.q_exp);
                check((dr >= -2) && (dr <= 2), "R4", "recip within 2 units",
                      {30'b0, recip}, mon_item.r_exp);
            end
            last_q = quotient;
            last_r = recip;
        end
    end

    // Driver: queue expectations, issue one request, check the handshake timing.
    // Called at a negedge; returns at the negedge of the first idle cycle.
    task automatic run_op(input logic [31:0] a, input logic [31:0] b,
                          input string tag, input bit stall);
        exp_t item;
        item.a     = a;
        item.b     = b;
        item.q_exp = ({32'b0, a} << 31) / {32'b0, b};
        item.r_exp = (b == 32'h8000_0000) ? 64'h2_0000_0000
                                          : 64'hFFFF_FFFF_FFFF_FFFF / {32'b0, b};
        item.tag   = tag;
        sb_q.push_back(item);
        dividend = a;
        divisor  = b;
        start    = 1'b1;
        @(negedge clk);
        check(busy == 1'b1, "R2 R10", "busy after accepted start", busy, 1);
        if (stall) begin
            // R3: keep requesting with other operands while busy
            dividend = ~a | 32'h8000_0000;
            divisor  = b ^ 32'h7FFF_0000;
        end else begin
            start = 1'b0;
        end
        for (int n = 1; n <= LAT; n++) begin
            @(negedge clk);
            if (stall && (n == 3)) start = 1'b0;
            check(done == (n == LAT), "R6", "done timing", done, (n == LAT));
        end
        @(negedge clk);
        check(done == 1'b0, "R7", "done dropped", done, 0);
        check(busy == 1'b0, "R7", "busy dropped", busy, 0);
    endtask

    // Watchdog: a hung run is one failed check and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Stimulus sequence.
    initial begin
        rst_n    = 1'b0;
        start    = 1'b0;
        dividend = '0;
        divisor  = 32'h8000_0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(busy == 1'b0, "R1", "busy after reset", busy, 0);
        check(done == 1'b0, "R1", "done after reset", done, 0);
        check(quotient == 32'h0, "R1", "quotient after reset", quotient, 0);
        check(recip == 34'h0, "R1", "recip after reset", recip, 0);

        // Boundary operands.
        run_op(32'h8000_0000, 32'h8000_0000, "R9", 1'b0);
        run_op(32'hFFFF_FFFF, 32'h8000_0000, "R9", 1'b0);
        run_op(32'h8000_0000, 32'hFFFF_FFFF, "R9", 1'b0);
        run_op(32'hC000_0000, 32'hC000_0000, "R9", 1'b0);
        run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R9", 1'b0);
        run_op(32'hABCD_1234, 32'h807F_FFFF, "R5", 1'b0);
        run_op(32'hABCD_1234, 32'h8080_0000, "R5", 1'b0);
        run_op(32'h9000_0001, 32'hFF80_0000, "R5", 1'b0);

        // R8: results hold while idle even as the inputs change.
        for (int i = 0; i < 4; i++) begin
            dividend = 32'h8000_0000 | $urandom;
            divisor  = 32'h8000_0000 | $urandom;
            @(negedge clk);
            check(quotient == last_q, "R8", "quotient held", quotient, last_q);
            check(recip == last_r, "R8", "recip held", recip, last_r);
        end

        // R3: requests while busy are ignored.
        run_op(32'hD000_0000, 32'hA000_0000, "R3", 1'b1);
        run_op(32'h8123_4567, 32'hF0F0_F0F0, "R3", 1'b1);

        // Random operands, back to back (R10).
        for (int i = 0; i < 40; i++) begin
            run_op(32'h8000_0000 | $urandom, 32'h8000_0000 | $urandom, "R5", 1'b0);
        end

        // R1: reset in the middle of an operation clears everything.
        dividend = 32'hE000_0000;
        divisor  = 32'h9000_0000;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(busy == 1'b0, "R1", "busy after mid-op reset", busy, 0);
        check(quotient == 32'h0, "R1", "quotient after mid-op reset", quotient, 0);
        check(recip == 34'h0, "R1", "recip after mid-op reset", recip, 0);
        rst_n = 1'b1;
        repeat (LAT + 2) @(negedge clk);
        check(done == 1'b0, "R1", "no done after mid-op reset", done, 0);

        // Operation after the reset still works.
        run_op(32'hB504_F334, 32'hB504_F334, "R9", 1'b0);
        check(sb_q.size() == 0, "R5", "scoreboard drained", sb_q.size(), 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule